// File: doc/BRIEF.md
# Display Control Register Decoder

This block sits behind the control port of a graphics processor. Each 32-bit word written to that port carries a command number in its top byte and an argument in the lower bits. The decoder keeps the display control registers, builds the status word, drives the display origin and the horizontal and vertical display window as plain outputs, and answers information queries through a latched read-back word. It also holds eight drawing-environment argument words, written through a separate side port, that the query command reads back.

All writes take effect on the clock edge that samples the strobe, so every output reflects a write one cycle after the strobe is high. The control port has no back-pressure: the decoder accepts one word on every cycle in which the strobe is high. Sixteen command numbers (0x00 to 0x0F) own a stored register. A write that repeats the stored value of a guarded command is dropped in full, so it causes no side effect and no change pulse.

Top module: `dispctl_decoder`

## Requirements
- R1: After `rst` is high for a clock edge, `status_word` is 0x14802000, every display origin and range output is zero, `query_word` is zero, `dims_changed` is low and every environment argument word is zero.
- R2: A control write with command 0x00 restores the status word, the control registers and the environment argument words to their R1 values on the next cycle and leaves `query_word` unchanged.
- R3: Command 0x03 copies argument bit 0 into status bit 23 (the blanking flag): 1 sets it and 0 clears it. All other status bits keep their value.
- R4: Command 0x04 copies argument bits 1:0 into status bits 30:29 (the DMA direction field). All other status bits keep their value.
- R5: Command 0x05 sets `disp_org_x` from bits 9:0 and `disp_org_y` from bits 18:10 of the written word.
- R6: Command 0x06 sets `hrange_start` from bits 11:0 and `hrange_end` from bits 23:12. Command 0x07 sets `vrange_start` from bits 9:0 and `vrange_end` from bits 19:10.
- R7: Command 0x08 clears status bits 22:16, then puts argument bits 5:0 into status bits 22:17 and argument bit 6 into status bit 16.
- R8: A write whose command lies in 0x02..0x0F but is not 0x05, and whose full 32-bit value equals the last value stored for that command since reset, is ignored. Command 0x05 writes are never ignored.
- R9: `dims_changed` is high for exactly the one cycle after each accepted write of command 0x06, 0x07 or 0x08, and is low at all other times.
- R10: A cycle with `env_wr_en` high stores `env_wr_arg` (22 bits) into the environment word selected by `env_wr_idx` (0..7). No other environment word changes.
- R11: A control write with a command in 0x10..0x1F is a query selected by its bits 3:0. Items 2, 3, 4 and 5 load `query_word` with environment word 2, 3, 4 or 5, cut to its low 20 bits. Item 6 loads environment word 5, cut to its low 22 bits. Any other item leaves `query_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr_en | input | 1 | Control word strobe, one word per high cycle |
| ctl_wr_data | input | 32 | Control word: command in 31:24, argument below |
| env_wr_en | input | 1 | Environment word strobe |
| env_wr_idx | input | 3 | Environment word index |
| env_wr_arg | input | 22 | Environment argument bits |
| status_word | output | 32 | Composed status word |
| query_word | output | 32 | Latched query answer |
| disp_org_x | output | 10 | Display source origin, horizontal |
| disp_org_y | output | 9 | Display source origin, vertical |
| hrange_start | output | 12 | Horizontal display range start |
| hrange_end | output | 12 | Horizontal display range end |
| vrange_start | output | 10 | Vertical display range start |
| vrange_end | output | 10 | Vertical display range end |
| dims_changed | output | 1 | One-cycle pulse after a range or mode register changes |

## Verification
The bench builds the decoder with its default sizes: sixteen stored control registers and eight environment words. At these sizes every guarded command number can be written twice in a row. This exercises the duplicate-drop rule on the range and mode commands, where the missing change pulse shows that the write was ignored. The same sizes make all query items reachable, including the 20-bit and 22-bit cuts and the items that leave the answer alone, and they allow a soft reset through command 0x00 to be observed in the middle of a sequence.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam int WORD_W   = 32;
  localparam int CMD_W    = 8;
  localparam int ENV_ARG_W = 22;

  localparam logic [WORD_W-1:0] STATUS_AT_RESET = 32'h1480_2000;

  localparam int BLANK_BIT = 23;
  localparam int DMA_HI    = 30;
  localparam int DMA_LO    = 29;
  localparam int MODE_HI   = 22;
  localparam int MODE_LO   = 16;

  localparam int QUERY_NARROW_W = 20;
  localparam int QUERY_WIDE_W   = 22;

  typedef enum logic [CMD_W-1:0] {
    CMD_SOFT_RESET  = 8'h00,
    CMD_FIFO_CLEAR  = 8'h01,
    CMD_IRQ_ACK     = 8'h02,
    CMD_BLANK       = 8'h03,
    CMD_DMA_DIR     = 8'h04,
    CMD_DISP_ORIGIN = 8'h05,
    CMD_HWINDOW     = 8'h06,
    CMD_VWINDOW     = 8'h07,
    CMD_VIDEO_MODE  = 8'h08
  } ctl_cmd_e;

  localparam logic [3:0] QUERY_GROUP = 4'h1;
endpackage

// File: rtl/dispctl_ctrl_regs.sv
module dispctl_ctrl_regs
  import dispctl_pkg::*;
#(
  parameter int NUM_CTRL = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              accept,
  output logic              soft_rst,
  output logic [WORD_W-1:0] origin_word,
  output logic [WORD_W-1:0] hwin_word,
  output logic [WORD_W-1:0] vwin_word
);
  localparam int IDX_W = $clog2(NUM_CTRL);

  logic [WORD_W-1:0] ctrl_q [NUM_CTRL];
  logic [CMD_W-1:0]  cmd;
  logic [IDX_W-1:0]  idx;
  logic              owns_reg;
  logic              guarded;
  logic              same_value;

  assign cmd        = wr_data[WORD_W-1 -: CMD_W];
  assign idx        = cmd[IDX_W-1:0];
  assign owns_reg   = int'(cmd) < NUM_CTRL;
  assign guarded    = owns_reg && (cmd > CMD_FIFO_CLEAR) && (cmd != CMD_DISP_ORIGIN);
  assign same_value = ctrl_q[idx] == wr_data;
  assign accept     = wr_en && !(guarded && same_value);
  assign soft_rst   = accept && (cmd == CMD_SOFT_RESET);

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst || soft_rst)
        ctrl_q[g] <= '0;
      else if (accept && owns_reg && (idx == IDX_W'(g)))
        ctrl_q[g] <= wr_data;
    end
  end

  assign origin_word = ctrl_q[CMD_DISP_ORIGIN];
  assign hwin_word   = ctrl_q[CMD_HWINDOW];
  assign vwin_word   = ctrl_q[CMD_VWINDOW];
endmodule

// File: rtl/dispctl_status.sv
module dispctl_status
  import dispctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [6:0]        arg,
  output logic [WORD_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= STATUS_AT_RESET;
    end else if (accept) begin
      case (cmd)
        CMD_SOFT_RESET: status_q <= STATUS_AT_RESET;
        CMD_BLANK:      status_q[BLANK_BIT] <= arg[0];
        CMD_DMA_DIR:    status_q[DMA_HI:DMA_LO] <= arg[1:0];
        CMD_VIDEO_MODE: status_q[MODE_HI:MODE_LO] <= {arg[5:0], arg[6]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dispctl_env_query.sv
module dispctl_env_query
  import dispctl_pkg::*;
#(
  parameter int NUM_ENV = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       soft_rst,
  input  logic                       env_wr_en,
  input  logic [$clog2(NUM_ENV)-1:0] env_wr_idx,
  input  logic [ENV_ARG_W-1:0]       env_wr_arg,
  input  logic                       query_en,
  input  logic [3:0]                 query_item,
  output logic [WORD_W-1:0]          query_q
);
  localparam int EIDX_W = $clog2(NUM_ENV);

  logic [ENV_ARG_W-1:0] env_q [NUM_ENV];

  for (genvar g = 0; g < NUM_ENV; g++) begin : g_env
    always_ff @(posedge clk) begin
      if (rst || soft_rst)
        env_q[g] <= '0;
      else if (env_wr_en && (env_wr_idx == EIDX_W'(g)))
        env_q[g] <= env_wr_arg;
    end
  end

  logic [ENV_ARG_W-1:0] picked;
  assign picked = env_q[query_item[EIDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      query_q <= '0;
    end else if (query_en) begin
      case (query_item)
        4'd2, 4'd3, 4'd4, 4'd5:
          query_q <= {{(WORD_W-QUERY_NARROW_W){1'b0}}, picked[QUERY_NARROW_W-1:0]};
        4'd6:
          query_q <= {{(WORD_W-QUERY_WIDE_W){1'b0}}, env_q[5][QUERY_WIDE_W-1:0]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dispctl_decoder.sv
module dispctl_decoder
  import dispctl_pkg::*;
#(
  parameter int NUM_CTRL = 16,
  parameter int NUM_ENV  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr_en,
  input  logic [31:0] ctl_wr_data,
  input  logic        env_wr_en,
  input  logic [2:0]  env_wr_idx,
  input  logic [21:0] env_wr_arg,
  output logic [31:0] status_word,
  output logic [31:0] query_word,
  output logic [9:0]  disp_org_x,
  output logic [8:0]  disp_org_y,
  output logic [11:0] hrange_start,
  output logic [11:0] hrange_end,
  output logic [9:0]  vrange_start,
  output logic [9:0]  vrange_end,
  output logic        dims_changed
);
  logic              accept;
  logic              soft_rst;
  logic [WORD_W-1:0] origin_word;
  logic [WORD_W-1:0] hwin_word;
  logic [WORD_W-1:0] vwin_word;
  logic [CMD_W-1:0]  cmd;
  logic              dims_q;

  assign cmd = ctl_wr_data[WORD_W-1 -: CMD_W];

  dispctl_ctrl_regs #(.NUM_CTRL(NUM_CTRL)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctl_wr_en),
    .wr_data    (ctl_wr_data),
    .accept     (accept),
    .soft_rst   (soft_rst),
    .origin_word(origin_word),
    .hwin_word  (hwin_word),
    .vwin_word  (vwin_word)
  );

  dispctl_status u_status (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .cmd     (cmd),
    .arg     (ctl_wr_data[6:0]),
    .status_q(status_word)
  );

  dispctl_env_query #(.NUM_ENV(NUM_ENV)) u_query (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .env_wr_en (env_wr_en),
    .env_wr_idx(env_wr_idx),
    .env_wr_arg(env_wr_arg),
    .query_en  (accept && (cmd[7:4] == QUERY_GROUP)),
    .query_item(ctl_wr_data[3:0]),
    .query_q   (query_word)
  );

  always_ff @(posedge clk) begin
    if (rst)
      dims_q <= 1'b0;
    else
      dims_q <= accept && ((cmd == CMD_HWINDOW) || (cmd == CMD_VWINDOW) ||
                           (cmd == CMD_VIDEO_MODE));
  end

  assign dims_changed = dims_q;
  assign disp_org_x   = origin_word[9:0];
  assign disp_org_y   = origin_word[18:10];
  assign hrange_start = hwin_word[11:0];
  assign hrange_end   = hwin_word[23:12];
  assign vrange_start = vwin_word[9:0];
  assign vrange_end   = vwin_word[19:10];
endmodule

// File: rtl/dispctl_decoder_chk.sv
module dispctl_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctl_wr_en,
  input logic [31:0] ctl_wr_data,
  input logic [31:0] status_word,
  input logic [11:0] hrange_start,
  input logic [11:0] hrange_end,
  input logic        dims_changed
);
  // R1: reset loads the fixed status value
  p_reset_status_r1: assert property (@(posedge clk)
    rst |=> status_word == 32'h1480_2000);

  // R2: command 0x00 restores the status value
  p_soft_reset_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data[31:24] == 8'h00) |=> status_word == 32'h1480_2000);

  // R3: blanking flag follows argument bit 0
  p_blank_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data[31:24] == 8'h03) |=> status_word[23] == $past(ctl_wr_data[0]));

  // R4: DMA direction field follows argument bits 1:0
  p_dma_dir_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data[31:24] == 8'h04) |=> status_word[30:29] == $past(ctl_wr_data[1:0]));

  // R6: horizontal window fields
  p_hwindow_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data[31:24] == 8'h06) |=>
      (hrange_start == $past(ctl_wr_data[11:0]) && hrange_end == $past(ctl_wr_data[23:12])));

  // R7: mode argument scattered into the status word
  p_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data[31:24] == 8'h08) |=>
      status_word[22:16] == {$past(ctl_wr_data[5:0]), $past(ctl_wr_data[6])});

  // R9: no change pulse without a write in the previous cycle
  p_dims_needs_write_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl_wr_en) |-> !dims_changed);
endmodule

bind dispctl_decoder dispctl_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_wr_data (ctl_wr_data),
  .status_word (status_word),
  .hrange_start(hrange_start),
  .hrange_end  (hrange_end),
  .dims_changed(dims_changed)
);

// File: tb/dispctl_decoder_test.sv
`timescale 1ns/1ps
module dispctl_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic        env_wr_en;
  logic [2:0]  env_wr_idx;
  logic [21:0] env_wr_arg;
  logic [31:0] status_word;
  logic [31:0] query_word;
  logic [9:0]  disp_org_x;
  logic [8:0]  disp_org_y;
  logic [11:0] hrange_start;
  logic [11:0] hrange_end;
  logic [9:0]  vrange_start;
  logic [9:0]  vrange_end;
  logic        dims_changed;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ctrl [16];
  logic [21:0] m_env  [8];
  logic [31:0] m_status;
  logic [31:0] m_query;

  always #4 clk = ~clk;

  dispctl_decoder uut (
    .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .env_wr_en(env_wr_en), .env_wr_idx(env_wr_idx), .env_wr_arg(env_wr_arg),
    .status_word(status_word), .query_word(query_word),
    .disp_org_x(disp_org_x), .disp_org_y(disp_org_y),
    .hrange_start(hrange_start), .hrange_end(hrange_end),
    .vrange_start(vrange_start), .vrange_end(vrange_end),
    .dims_changed(dims_changed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) m_ctrl[i] = '0;
    for (int i = 0; i < 8; i++) m_env[i] = '0;
    m_status = 32'h1480_2000;
  endtask

  task automatic check_outputs(input string req, input logic exp_dims);
    chk({req, " status"}, status_word, m_status);
    chk({req, " origin"}, {13'd0, disp_org_y, disp_org_x}, {13'd0, m_ctrl[5][18:10], m_ctrl[5][9:0]});
    chk({req, " hwin"}, {8'd0, hrange_end, hrange_start}, {8'd0, m_ctrl[6][23:12], m_ctrl[6][11:0]});
    chk({req, " vwin"}, {12'd0, vrange_end, vrange_start}, {12'd0, m_ctrl[7][19:10], m_ctrl[7][9:0]});
    chk({req, " query"}, query_word, m_query);
    chk({req, " dims"}, {31'd0, dims_changed}, {31'd0, exp_dims});
  endtask

  task automatic ctl_write(input logic [31:0] data, input string req);
    logic [7:0] cmd;
    logic       acc;
    logic       exp_dims;
    cmd = data[31:24];
    acc = !((cmd < 8'd16) && (cmd > 8'd1) && (cmd != 8'd5) && (m_ctrl[cmd[3:0]] == data));
    exp_dims = 1'b0;
    if (acc) begin
      if (cmd < 8'd16) m_ctrl[cmd[3:0]] = data;
      case (cmd)
        8'h00: model_clear();
        8'h03: m_status[23] = data[0];
        8'h04: m_status[30:29] = data[1:0];
        8'h08: m_status[22:16] = {data[5:0], data[6]};
        default: ;
      endcase
      if (cmd == 8'h06 || cmd == 8'h07 || cmd == 8'h08) exp_dims = 1'b1;
      if (cmd[7:4] == 4'h1) begin
        if (data[3:0] >= 4'd2 && data[3:0] <= 4'd5) m_query = {12'd0, m_env[data[2:0]][19:0]};
        else if (data[3:0] == 4'd6) m_query = {10'd0, m_env[5]};
      end
    end
    @(negedge clk);
    ctl_wr_en = 1'b1;
    ctl_wr_data = data;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    check_outputs(req, exp_dims);
  endtask

  task automatic env_write(input logic [2:0] idx, input logic [21:0] arg);
    m_env[idx] = arg;
    @(negedge clk);
    env_wr_en = 1'b1;
    env_wr_idx = idx;
    env_wr_arg = arg;
    @(negedge clk);
    env_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    m_query = '0;
    chk("R1 status literal", status_word, 32'h1480_2000);
    check_outputs("R1", 1'b0);
  endtask

  task automatic t_blank();
    ctl_write(32'h0300_0000, "R3 clear");
    chk("R3 literal", status_word, 32'h1400_2000);
    ctl_write(32'h0300_0001, "R3 set");
    chk("R3 literal", status_word, 32'h1480_2000);
  endtask

  task automatic t_dma();
    ctl_write(32'h0400_0002, "R4 dir2");
    chk("R4 literal", status_word, 32'h5480_2000);
    ctl_write(32'h0400_0001, "R4 dir1");
    chk("R4 literal", status_word, 32'h3480_2000);
  endtask

  task automatic t_origin();
    ctl_write(32'h0506_83FF, "R5 origin");
    chk("R5 x literal", {22'd0, disp_org_x}, 32'h3FF);
    chk("R5 y literal", {23'd0, disp_org_y}, 32'h1A0);
    ctl_write(32'h0506_83FF, "R8 origin repeat");
  endtask

  task automatic t_windows();
    ctl_write(32'h0612_3456, "R6 hwin");
    chk("R6 start literal", {20'd0, hrange_start}, 32'h456);
    chk("R6 end literal", {20'd0, hrange_end}, 32'h123);
    @(negedge clk);
    chk("R9 pulse ends", {31'd0, dims_changed}, 32'd0);
    ctl_write(32'h070A_BCDE, "R6 vwin");
    chk("R6 vstart literal", {22'd0, vrange_start}, 32'h0DE);
    chk("R6 vend literal", {22'd0, vrange_end}, 32'h2AF);
  endtask

  task automatic t_mode();
    ctl_write(32'h0800_0041, "R7 mode");
    chk("R7 literal", status_word, 32'h3483_2000);
    ctl_write(32'h0800_007F, "R7 mode all");
    chk("R7 literal", status_word, 32'h34FF_2000);
  endtask

  task automatic t_suppress();
    ctl_write(32'h0800_007F, "R8 mode repeat");
    ctl_write(32'h0612_3456, "R8 hwin repeat");
    ctl_write(32'h0612_3457, "R9 hwin change");
    ctl_write(32'h0300_0001, "R8 blank repeat");
  endtask

  task automatic t_env_query();
    env_write(3'd2, 22'h0A_BCDE);
    env_write(3'd5, 22'h3A_BCDE);
    env_write(3'd4, 22'h1F_0001);
    ctl_write(32'h1000_0002, "R11 item2");
    chk("R10 literal", query_word, 32'h000A_BCDE);
    ctl_write(32'h1000_0006, "R11 item6");
    chk("R11 literal wide", query_word, 32'h003A_BCDE);
    ctl_write(32'h1000_0005, "R11 item5");
    chk("R11 literal narrow", query_word, 32'h000A_BCDE);
    ctl_write(32'h1000_0000, "R11 item0 ignored");
    chk("R11 literal keep", query_word, 32'h000A_BCDE);
    ctl_write(32'h1F00_0014, "R11 item4 high bits");
    chk("R10 literal idx4", query_word, 32'h000F_0001);
    ctl_write(32'h1000_0003, "R10 untouched idx3");
    chk("R10 literal idx3", query_word, 32'h0000_0000);
  endtask

  task automatic t_soft_reset();
    ctl_write(32'h0400_0003, "R4 dir3");
    ctl_write(32'h1000_0002, "R11 before soft");
    ctl_write(32'h0000_0000, "R2 soft");
    chk("R2 status literal", status_word, 32'h1480_2000);
    chk("R2 query kept", query_word, 32'h000A_BCDE);
    ctl_write(32'h1000_0002, "R2 env cleared");
    chk("R2 env literal", query_word, 32'h0);
    ctl_write(32'h0300_0000, "R2 regs cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    ctl_wr_en = 1'b0;
    ctl_wr_data = '0;
    env_wr_en = 1'b0;
    env_wr_idx = '0;
    env_wr_arg = '0;
    t_reset();
    t_blank();
    t_dma();
    t_origin();
    t_windows();
    t_mode();
    t_suppress();
    t_env_query();
    t_soft_reset();
    t_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule